// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a synthesizable model of a 256-byte serial EEPROM that answers on a two-wire bus. A fast system clock samples the bus clock and data lines. The block finds start and stop conditions in the samples and answers only to its own device address. That address is a fixed code followed by three strap inputs. The data line is open-drain. The block never drives it high. It only asserts a separate pull-low output, and the bench or pad combines that output with the bus.

A write carries one word-address byte and then up to one page of data (8 bytes). The data goes into a page buffer. The array is updated only when a stop condition is followed by a timed internal write cycle. During that cycle the block ignores the bus completely, so a controller can poll it with address bytes until it acknowledges again. A read returns bytes starting at an internal address counter, which persists between transactions. To read from a chosen address, the controller sends a write header with the word address only, then a repeated start and a read header. A write-protect input blocks all changes to the array.

Top module: `tw_eeprom_target`

## Requirements
- R1: A falling data line while the clock is high is a start; a rising data line while the clock is high is a stop. A start seen at any point, including mid-byte, abandons the current transfer and begins reception of a new address byte.
- R2: The address byte is `1010` in bits 7..4, the strap value in bits 3..1, and a direction bit in bit 0 (1 = read). Any other value gets no acknowledge, and the line stays released until the next start.
- R3: Every accepted received byte (address, word address, data) is acknowledged by pulling the data line low through the ninth clock.
- R4: A write is the address byte with bit 0 = 0, a word-address byte, and data bytes. After the stop, and once the internal write cycle ends, each byte is found in the array at its address.
- R5: During a write only the low 3 address bits advance. After offset 7 the next byte goes to offset 0 of the same 8-byte page, so bytes beyond eight overwrite earlier ones.
- R6: The address counter holds the last accessed address plus one and keeps its value between transactions. A read that follows the address byte directly starts there.
- R7: Sequential reads continue while the controller acknowledges each byte. The address wraps from 0xFF to 0x00. A controller non-acknowledge ends the transfer.
- R8: For WR_CYCLES system clocks after the stop that ends a write with data, the block ignores the bus, does not acknowledge its address and never pulls the line. After that window it acknowledges again.
- R9: With write-protect high, data bytes are still acknowledged and the counter still advances, but the array keeps its contents and no write cycle starts.
- R10: A write header with a word address only, followed by a repeated start and a read header, returns data from that word address.
- R11: The pull-low output changes only while the sampled bus clock is low.
- R12: After reset the line is released, the address counter is 0, and every array byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 3 | Hard-wired address strap value |
| wp_i | input | 1 | Write-protect, high blocks array changes |
| sda_pull_o | output | 1 | High pulls the data line low |

## Verification
The end of the internal write cycle can fall in the same system cycle as an incoming polling start, or within a few cycles of it. Release of the busy state and decoding of a new address then compete. The bench provokes this by polling back to back right after each committed write, so that one poll straddles the end of the window. The reference model counts clocks from the stop. It requires a non-acknowledge for any poll that starts inside the window and an acknowledge for any poll that starts clearly after it. It also requires that the first acknowledged poll starts no earlier than the window end. On every clock inside the window it checks that the line is never pulled.

// File: rtl/tw_eeprom_pkg.sv
// Package: shared constants and state encoding for the two-wire EEPROM target.
// Assumes an 8-bit data path on the bus; address widths come from the modules.
package tw_eeprom_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_RDATA
    } tw_state_e;
endpackage

// File: rtl/tw_line_sampler.sv
// Line sampler: synchronises the bus clock and data lines to clk and flags
// clock edges and start/stop conditions. Assumes the bus is several times
// slower than clk so that every level lasts at least a few samples.
module tw_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_d;
    logic                   sda_d;

    // Synchroniser chains and one-sample history; idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_sync[SYNC_STAGES-1];
            sda_d    <= sda_sync[SYNC_STAGES-1];
        end
    end

    // Edge and condition decode from current and previous samples.
    always_comb begin
        scl_s     = scl_sync[SYNC_STAGES-1];
        sda_s     = sda_sync[SYNC_STAGES-1];
        scl_rise  = scl_s && !scl_d;
        scl_fall  = !scl_s && scl_d;
        start_det = scl_s && scl_d && sda_d && !sda_s;
        stop_det  = scl_s && scl_d && !sda_d && sda_s;
    end
endmodule

// File: rtl/tw_cell_store.sv
// Cell store: the byte array, a one-page write buffer and the timed
// internal write cycle. Buffered bytes reach the array only on the last
// clock of the cycle. Assumes the controller never requests a cycle while
// one is running.
module tw_cell_store #(
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 3,
    parameter int WR_CYCLES = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              buf_clear,
    input  logic              buf_we,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_data,
    input  logic              cycle_go,
    output logic              busy_o
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int ROW_W      = ADDR_W - PAGE_W;
    localparam int CNT_W      = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLES - 1);

    logic [7:0]            mem  [DEPTH];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask;
    logic [ROW_W-1:0]      prow;
    logic [CNT_W-1:0]      cnt;
    logic                  busy;
    logic                  commit;

    assign commit  = busy && (cnt == CNT_LAST);
    assign busy_o  = busy;
    assign rd_data = mem[rd_addr];

    // Write-cycle timer: runs WR_CYCLES clocks from a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (cycle_go && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (commit) busy <= 1'b0;
            else        cnt  <= cnt + 1'b1;
        end
    end

    // Page buffer valid mask and row: cleared per transaction and on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pmask <= '0;
            prow  <= '0;
        end else if (buf_clear || commit) begin
            pmask <= '0;
        end else if (buf_we) begin
            pmask[buf_addr[PAGE_W-1:0]] <= 1'b1;
            prow                        <= buf_addr[ADDR_W-1:PAGE_W];
        end
    end

    // Page buffer data bytes.
    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_addr[PAGE_W-1:0]] <= buf_data;
    end

    // Array: cleared by reset, written from the buffer at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (commit) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (pmask[j]) mem[{prow, PAGE_W'(j)}] <= pbuf[j];
            end
        end
    end

    // R8
    go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_go |-> !busy);
endmodule

// File: rtl/tw_target_fsm.sv
// Target protocol engine: receives and sends bytes on sampled clock edges,
// matches the device address, keeps the address counter, drives the
// acknowledge and read data through a pull-low output. Assumes ADDR_W <= 8.
module tw_target_fsm
    import tw_eeprom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        strap_i,
    input  logic              wp_i,
    input  logic              busy_i,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [7:0]        rd_data_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              buf_clear_o,
    output logic              buf_we_o,
    output logic [ADDR_W-1:0] buf_addr_o,
    output logic [7:0]        buf_data_o,
    output logic              cycle_go_o,
    output logic              sda_pull_o
);
    tw_state_e         st;
    logic [3:0]        bit_cnt;
    logic              ack_ph;
    logic [7:0]        shreg;
    logic [7:0]        txreg;
    logic [ADDR_W-1:0] ptr;
    logic              pull;
    logic              pend;
    logic              host_ack;
    logic              dev_hit;

    assign ptr_o      = ptr;
    assign sda_pull_o = pull;

    // Address byte comparison against the fixed code and the straps.
    always_comb begin
        dev_hit = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == strap_i);
    end

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            bit_cnt     <= '0;
            ack_ph      <= 1'b0;
            shreg       <= '0;
            txreg       <= '0;
            ptr         <= '0;
            pull        <= 1'b0;
            pend        <= 1'b0;
            host_ack    <= 1'b0;
            buf_clear_o <= 1'b0;
            buf_we_o    <= 1'b0;
            buf_addr_o  <= '0;
            buf_data_o  <= '0;
            cycle_go_o  <= 1'b0;
        end else begin
            buf_clear_o <= 1'b0;
            buf_we_o    <= 1'b0;
            cycle_go_o  <= 1'b0;
            if (busy_i) begin
                st     <= ST_IDLE;
                pull   <= 1'b0;
                ack_ph <= 1'b0;
            end else if (start_det) begin
                st      <= ST_DEV;
                bit_cnt <= '0;
                ack_ph  <= 1'b0;
                pull    <= 1'b0;
                pend    <= 1'b0;
            end else if (stop_det) begin
                cycle_go_o <= pend;
                st         <= ST_IDLE;
                ack_ph     <= 1'b0;
                pull       <= 1'b0;
                pend       <= 1'b0;
            end else if (st != ST_IDLE) begin
                if (scl_rise) begin
                    if (!ack_ph) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else begin
                        host_ack <= !sda_s;
                    end
                end else if (scl_fall) begin
                    if (!ack_ph && bit_cnt == 4'd8) begin
                        bit_cnt <= '0;
                        ack_ph  <= 1'b1;
                        case (st)
                            ST_DEV: begin
                                if (dev_hit) pull <= 1'b1;
                                else         st   <= ST_IDLE;
                            end
                            ST_WADDR: begin
                                pull        <= 1'b1;
                                ptr         <= shreg[ADDR_W-1:0];
                                buf_clear_o <= 1'b1;
                            end
                            ST_WDATA: begin
                                pull       <= 1'b1;
                                buf_we_o   <= !wp_i;
                                buf_addr_o <= ptr;
                                buf_data_o <= shreg;
                                pend       <= pend || !wp_i;
                                ptr        <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                            end
                            ST_RDATA: begin
                                pull <= 1'b0;
                                ptr  <= ptr + 1'b1;
                            end
                            default: ;
                        endcase
                    end else if (ack_ph) begin
                        ack_ph <= 1'b0;
                        case (st)
                            ST_DEV: begin
                                if (shreg[0]) begin
                                    st    <= ST_RDATA;
                                    txreg <= rd_data_i;
                                    pull  <= !rd_data_i[7];
                                end else begin
                                    st   <= ST_WADDR;
                                    pull <= 1'b0;
                                end
                            end
                            ST_WADDR: begin
                                st   <= ST_WDATA;
                                pull <= 1'b0;
                            end
                            ST_WDATA: pull <= 1'b0;
                            ST_RDATA: begin
                                if (host_ack) begin
                                    txreg <= rd_data_i;
                                    pull  <= !rd_data_i[7];
                                end else begin
                                    st   <= ST_IDLE;
                                    pull <= 1'b0;
                                end
                            end
                            default: pull <= 1'b0;
                        endcase
                    end else if (st == ST_RDATA) begin
                        pull  <= !txreg[6];
                        txreg <= {txreg[6:0], 1'b0};
                    end
                end
            end
        end
    end

    // R11
    pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pull != $past(pull)) |-> !scl_s);

    // R5
    page_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WDATA) |=> (st != ST_WDATA) ||
                              (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !pull);
endmodule

// File: rtl/tw_eeprom_target.sv
// Top: two-wire serial EEPROM target. Joins the line sampler, the protocol
// engine and the cell store. Assumes an external pull-up on the data line;
// sda_pull_o high means the pad pulls the line low.
module tw_eeprom_target #(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 3,
    parameter int WR_CYCLES   = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_pull_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        rd_data;
    logic              buf_clear, buf_we, cycle_go, busy;
    logic [ADDR_W-1:0] buf_addr;
    logic [7:0]        buf_data;

    tw_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tw_target_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (strap_i),
        .wp_i        (wp_i),
        .busy_i      (busy),
        .scl_s       (scl_s),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .rd_data_i   (rd_data),
        .ptr_o       (ptr),
        .buf_clear_o (buf_clear),
        .buf_we_o    (buf_we),
        .buf_addr_o  (buf_addr),
        .buf_data_o  (buf_data),
        .cycle_go_o  (cycle_go),
        .sda_pull_o  (sda_pull_o)
    );

    tw_cell_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (ptr),
        .rd_data   (rd_data),
        .buf_clear (buf_clear),
        .buf_we    (buf_we),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data),
        .cycle_go  (cycle_go),
        .busy_o    (busy)
    );

    // R8
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull_o);
endmodule

// File: tb/tw_eeprom_target_tb.sv
// Bench: drives the bus as a controller and keeps a behavioural model
// (byte array, address counter, cycle count of the last committing stop).
module tw_eeprom_target_tb;
    localparam int WR = 1500;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic tb_sda = 1'b1;
    logic wp = 1'b0;
    logic dut_pull;
    logic sda_line;

    assign sda_line = tb_sda && !dut_pull;

    always #2 clk = ~clk;

    tw_eeprom_target #(.WR_CYCLES(WR)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .strap_i    (STRAP),
        .wp_i       (wp),
        .sda_pull_o (dut_pull)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int stop_cyc = -100000;
    int start_cyc = 0;
    int quiet_viol = 0;
    logic quiet_exp = 1'b0;
    logic done = 1'b0;
    logic [7:0] mem_m [256];
    logic [7:0] ptr_m = 8'h00;

    always @(posedge clk) cyc <= cyc + 1;

    // Per-clock model comparison: line must stay released in silent windows (R2, R8).
    always @(negedge clk) begin
        if (rst_n && dut_pull && (quiet_exp || (cyc > stop_cyc && cyc < stop_cyc + WR)))
            quiet_viol <= quiet_viol + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic seen);
        tb_sda = b;
        wait_clk(4);
        scl = 1'b1;
        wait_clk(4);
        seen = sda_line;
        wait_clk(4);
        scl = 1'b0;
        wait_clk(4);
    endtask

    task automatic do_start();
        tb_sda = 1'b1;
        wait_clk(4);
        scl = 1'b1;
        wait_clk(4);
        tb_sda = 1'b0;
        start_cyc = cyc;
        wait_clk(4);
        scl = 1'b0;
        wait_clk(4);
    endtask

    task automatic do_stop();
        tb_sda = 1'b0;
        wait_clk(4);
        scl = 1'b1;
        wait_clk(4);
        tb_sda = 1'b1;
        wait_clk(8);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(d[i], s);
        bit_io(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            d[i] = s;
        end
        bit_io(!give_ack, s);
    endtask

    // Full write transaction; model updates the array unless protected.
    task automatic do_write(input logic [7:0] a, input logic [7:0] q[$], input string tag);
        logic ack;
        logic [2:0] off;
        off = a[2:0];
        do_start();
        send_byte(DEV_W, ack);
        check(ack, {tag, " address ack"}, ack, 1);
        send_byte(a, ack);
        check(ack, {tag, " word address ack"}, ack, 1);
        foreach (q[k]) begin
            send_byte(q[k], ack);
            check(ack, {tag, " data ack"}, ack, 1);
            if (!wp) mem_m[{a[7:3], off}] = q[k];
            off = off + 3'd1;
        end
        ptr_m = {a[7:3], off};
        do_stop();
        if (!wp && q.size() > 0) stop_cyc = cyc;
    endtask

    // Acknowledge polling until the block answers again.
    task automatic poll_ready(input string tag);
        logic ack;
        logic got;
        int polls;
        got = 1'b0;
        polls = 0;
        while (!got && polls < 40) begin
            do_start();
            send_byte(DEV_W, ack);
            do_stop();
            polls++;
            if (ack) begin
                got = 1'b1;
                check(start_cyc >= stop_cyc + WR, {tag, " R8 ack only after write cycle"},
                      start_cyc - stop_cyc, WR);
            end else begin
                check(start_cyc <= stop_cyc + WR + 8, {tag, " R8 nack only inside write cycle"},
                      start_cyc - stop_cyc, WR);
            end
            if (polls == 1)
                check(!ack, {tag, " R8 first poll refused"}, ack, 0);
        end
        check(got, {tag, " R8 block answers after write cycle"}, got, 1);
    endtask

    // Dummy write for the word address, repeated start, sequential read (R10, R7).
    task automatic rand_read(input logic [7:0] a, input int n, input string tag);
        logic ack;
        logic [7:0] d;
        do_start();
        send_byte(DEV_W, ack);
        check(ack, {tag, " R10 header ack"}, ack, 1);
        send_byte(a, ack);
        check(ack, {tag, " R10 word address ack"}, ack, 1);
        do_start();
        send_byte(DEV_R, ack);
        check(ack, {tag, " R10 read header ack"}, ack, 1);
        ptr_m = a;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            check(d == mem_m[ptr_m], tag, d, mem_m[ptr_m]);
            ptr_m = ptr_m + 8'd1;
        end
        do_stop();
    endtask

    task automatic cur_read(input int n, input string tag);
        logic ack;
        logic [7:0] d;
        do_start();
        send_byte(DEV_R, ack);
        check(ack, {tag, " read header ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            check(d == mem_m[ptr_m], tag, d, mem_m[ptr_m]);
            ptr_m = ptr_m + 8'd1;
        end
        do_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic s;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        wait_clk(6);
        rst_n = 1'b1;
        wait_clk(4);
        // R12: line released after reset
        check(dut_pull == 1'b0, "R12 line released after reset", dut_pull, 0);
        // R12, R6: counter starts at 0 and array reads zero
        cur_read(1, "R12 R6 read after reset");

        // R2: strap mismatch and wrong fixed code get no acknowledge
        quiet_exp = 1'b1;
        do_start();
        send_byte({4'b1010, 3'b001, 1'b0}, ack);
        check(!ack, "R2 strap mismatch nack", ack, 0);
        send_byte(8'h00, ack);
        check(!ack, "R2 silent after mismatch", ack, 0);
        do_stop();
        do_start();
        send_byte({4'b1011, STRAP, 1'b1}, ack);
        check(!ack, "R2 wrong code nack", ack, 0);
        do_stop();
        quiet_exp = 1'b0;

        // R4, R3: single byte write, polling, read back
        do_write(8'h10, '{8'hA5}, "R4 R3 byte write");
        poll_ready("R4 byte write");
        rand_read(8'h10, 1, "R4 byte readback");

        // R5: ten bytes from offset 5 wrap inside page 0x18
        do_write(8'h1D, '{8'h30, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39},
                 "R5 page write");
        poll_ready("R5 page write");
        // R6: counter is last written address plus one within the page
        cur_read(1, "R6 current address after page write");
        rand_read(8'h18, 8, "R5 R7 page readback");

        // R7: sequential read wraps from 0xFF to 0x00
        do_write(8'hFE, '{8'hC1, 8'hC2}, "R7 tail write");
        poll_ready("R7 tail write");
        rand_read(8'hFE, 4, "R7 sequential wrap");
        // R6: counter persists after the read
        cur_read(2, "R6 counter persists");

        // R9: protected write acked, no busy, array unchanged
        wp = 1'b1;
        do_write(8'h10, '{8'h77}, "R9 protected write");
        do_start();
        send_byte(DEV_W, ack);
        do_stop();
        check(ack, "R9 no write cycle when protected", ack, 1);
        wp = 1'b0;
        rand_read(8'h10, 1, "R9 array kept");

        // R1: start in the middle of the word address aborts it
        do_start();
        send_byte(DEV_W, ack);
        for (int i = 0; i < 4; i++) bit_io(1'b1, s);
        rand_read(8'h1A, 2, "R1 restart mid byte");

        check(quiet_viol == 0, "R2 R8 line quiet in silent windows", quiet_viol, 0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule